// File: doc/BRIEF.md
# Cache Block Refill Controller with Early Restart

This controller handles a read miss by pulling an eight-word block from a slow main memory into the cache. The memory needs a long wait before it returns the first word. After that it returns one word per cycle. Words always come in ascending order, starting at word 0 of the block. Each word goes out on a cache write port as soon as it arrives. The processor's word is handed back in the same cycle that word reaches the write port. The rest of the block keeps streaming in behind it, so the processor does not wait for the whole transfer.

A small fill buffer holds the words of the block being refilled, each with its own valid bit. A later request to that block for a word that has already arrived is answered from the buffer straight away. A request for a word that has not arrived yet is answered the moment it does. A miss to a different block is held off until the current refill is complete. The line valid bit and tag are committed only when the eighth word is written, through a one-cycle commit pulse. Tag lookup stays outside the block: the surrounding cache reports a hit on a committed line through `lookup_hit`, and the controller leaves such requests alone.

The processor holds `req_valid` steady until `cpu_done` pulses. It then drops the request for at least one cycle.

Top module: `lt_refill_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, `cpu_done`, `mem_req`, `cwr_en` and `line_commit` are all 0.
- R2: A request with `lookup_hit` low, made while no refill is active, is sampled at a clock edge. `mem_req` is then 1 for exactly one cycle starting right after that edge, with `act_line` equal to the requested line.
- R3: Each word accepted with `mem_valid` appears on the cache write port (`cwr_en`=1) in the next cycle. The k-th word of a refill carries index k on `cwr_word`, for k=0 to 7, together with its data.
- R4: For a miss, `cpu_done` pulses with the requested word on `cpu_data` in the same cycle that this word is on the cache write port. It does not wait for the words after it.
- R5: A request to the block being refilled, for a word already received, is answered with `cpu_done` in the cycle after it is sampled, using the buffered data.
- R6: A miss to a different line during a refill raises no `mem_req` while the refill is active. Its refill starts at the first edge after the commit cycle.
- R7: `line_commit` is 1 for one cycle, with `act_line` naming the block, exactly in the cycle when word 7 is on the cache write port and at no other time.
- R8: A request with `lookup_hit` high causes no `cpu_done` and no `mem_req`.
- R9: `cpu_done` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor read request, held until `cpu_done` |
| req_line | input | LINE_W | Block address of the request |
| req_word | input | $clog2(WORDS) | Word within the block |
| lookup_hit | input | 1 | Tag lookup found the block in a committed line |
| cpu_done | output | 1 | One-cycle release of the processor |
| cpu_data | output | DATA_W | Requested word, valid with `cpu_done` |
| mem_req | output | 1 | One-cycle block read command to main memory |
| act_line | output | LINE_W | Block being refilled (for memory, write port and commit) |
| mem_valid | input | 1 | Main memory presents a word |
| mem_data | input | DATA_W | Word from main memory |
| cwr_en | output | 1 | Cache data write strobe |
| cwr_word | output | $clog2(WORDS) | Word index being written |
| cwr_data | output | DATA_W | Data being written |
| line_commit | output | 1 | Sets the valid bit and tag of `act_line` |

## Verification
Two functions can fall in the same cycle: the early release of the processor and the commit of the line. When the requested word is word 7, its arrival releases the processor and also ends the refill. The bench provokes this with directed misses to word 7 and with random requests that hit the tail of a refill. It then checks that `cpu_done`, the word-7 write and `line_commit` all occur in one cycle. A second coincidence occurs when a request to the refilling block is sampled at the very edge where its word arrives. The bench predicts every release cycle from its own memory timing model: the maximum of the request cycle and the word's arrival cycle, with stalled misses shifted to the cycle after commit.

// File: rtl/lt_refill_pkg.sv
package lt_refill_pkg;

  typedef enum logic {FS_IDLE, FS_FILL} fill_st_e;

  // true when idx is the final beat of a block of the given size
  function automatic logic idx_is_last(input int unsigned idx, input int unsigned words);
    return idx == words - 1;
  endfunction

  // ascending beat order, wrapping at the block size
  function automatic int unsigned next_idx(input int unsigned idx, input int unsigned words);
    return (idx + 1) % words;
  endfunction

endpackage

// File: rtl/lt_fill_seq.sv
module lt_fill_seq
  import lt_refill_pkg::*;
#(
  parameter int WORDS = 8,
  localparam int WIDX = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            mem_valid,
  output logic            busy,
  output logic [WIDX-1:0] cnt,
  output logic            beat,
  output logic            last_beat
);

  fill_st_e st_q;

  assign busy      = (st_q == FS_FILL);
  assign beat      = busy && mem_valid;
  assign last_beat = beat && idx_is_last(32'(cnt), WORDS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= FS_IDLE;
      cnt  <= '0;
    end else begin
      unique case (st_q)
        FS_IDLE: if (start) begin
          st_q <= FS_FILL;
          cnt  <= '0;
        end
        FS_FILL: if (beat) begin
          cnt <= WIDX'(next_idx(32'(cnt), WORDS));
          if (last_beat) st_q <= FS_IDLE;
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lt_fill_buf.sv
module lt_fill_buf #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int WIDX  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [WIDX-1:0]   wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [WIDX-1:0]   rd_idx,
  output logic [WORDS-1:0]  wv,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] slot_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        wv[g] <= 1'b0;
      end else if (wr_en && wr_idx == WIDX'(g)) begin
        wv[g] <= 1'b1;
      end
      if (wr_en && wr_idx == WIDX'(g)) slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/lt_refill_ctrl.sv
module lt_refill_ctrl #(
  parameter int LINE_W = 6,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int WIDX  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_line,
  input  logic [WIDX-1:0]   req_word,
  input  logic              lookup_hit,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_data,
  output logic              mem_req,
  output logic [LINE_W-1:0] act_line,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data,
  output logic              cwr_en,
  output logic [WIDX-1:0]   cwr_word,
  output logic [DATA_W-1:0] cwr_data,
  output logic              line_commit
);

  // named internal events
  logic              busy, beat, last_beat;
  logic [WIDX-1:0]   fill_cnt;
  logic [WORDS-1:0]  fill_wv;
  logic [DATA_W-1:0] buf_rd;
  logic              miss_req, same_line, start, buf_hit, lt_hit;
  logic [LINE_W-1:0] fill_line_q;

  assign miss_req  = req_valid && !lookup_hit && !cpu_done;
  assign same_line = busy && (req_line == fill_line_q);
  assign start     = !busy && miss_req;
  assign buf_hit   = miss_req && same_line && fill_wv[req_word];
  assign lt_hit    = miss_req && same_line && beat && (fill_cnt == req_word);

  lt_fill_seq #(.WORDS(WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_valid(mem_valid),
    .busy(busy), .cnt(fill_cnt), .beat(beat), .last_beat(last_beat)
  );

  lt_fill_buf #(.WORDS(WORDS), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clear(start), .wr_en(beat),
    .wr_idx(fill_cnt), .wr_data(mem_data), .rd_idx(req_word),
    .wv(fill_wv), .rd_data(buf_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_line_q <= '0;
      mem_req     <= 1'b0;
      cwr_en      <= 1'b0;
      cwr_word    <= '0;
      cwr_data    <= '0;
      line_commit <= 1'b0;
      cpu_done    <= 1'b0;
      cpu_data    <= '0;
    end else begin
      mem_req     <= start;
      if (start) fill_line_q <= req_line;
      cwr_en      <= beat;
      if (beat) begin
        cwr_word <= fill_cnt;
        cwr_data <= mem_data;
      end
      line_commit <= last_beat;
      cpu_done    <= buf_hit || lt_hit;
      if (buf_hit)     cpu_data <= buf_rd;
      else if (lt_hit) cpu_data <= mem_data;
    end
  end

  assign act_line = fill_line_q;

endmodule

// File: rtl/lt_refill_chk.sv
module lt_refill_chk #(
  parameter int WORDS = 8,
  localparam int WIDX = $clog2(WORDS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            lookup_hit,
  input logic            busy,
  input logic            mem_req,
  input logic            cwr_en,
  input logic [WIDX-1:0] cwr_word,
  input logic [WORDS-1:0] wv,
  input logic            line_commit,
  input logic            cpu_done
);

  a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  a_r6_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !mem_req);

  a_r3_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr_en && cwr_word != '0) |-> wv[cwr_word - 1'b1]);

  a_r7_commit_last: assert property (@(posedge clk) disable iff (!rst_n)
    line_commit |-> (cwr_en && cwr_word == WIDX'(WORDS - 1)));

  a_r8_hit_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lookup_hit) |=> !mem_req);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

endmodule

bind lt_refill_ctrl lt_refill_chk #(.WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .lookup_hit(lookup_hit),
  .busy(busy), .mem_req(mem_req), .cwr_en(cwr_en), .cwr_word(cwr_word),
  .wv(fill_wv), .line_commit(line_commit), .cpu_done(cpu_done)
);

// File: tb/sim_lt_refill_ctrl.sv
module sim_lt_refill_ctrl;
  localparam int LW = 6, DW = 32, NW = 8, WI = 3, FIRST = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [LW-1:0] req_line = '0;
  logic [WI-1:0] req_word = '0;
  logic lookup_hit;
  logic cpu_done, mem_req, cwr_en, line_commit;
  logic [DW-1:0] cpu_data, cwr_data;
  logic [LW-1:0] act_line;
  logic [WI-1:0] cwr_word;
  logic mem_valid = 1'b0;
  logic [DW-1:0] mem_data = '0;

  int checks = 0, fails = 0, cyc = 0;
  bit committed [1<<LW];
  bit fill_on = 0, mem_act = 0;
  int fill_start = 0, seq = 0, mcnt = 0, memw = 0;
  logic [LW-1:0] fl = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign lookup_hit = committed[req_line];

  lt_refill_ctrl #(.LINE_W(LW), .DATA_W(DW), .WORDS(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
    .req_word(req_word), .lookup_hit(lookup_hit), .cpu_done(cpu_done),
    .cpu_data(cpu_data), .mem_req(mem_req), .act_line(act_line),
    .mem_valid(mem_valid), .mem_data(mem_data), .cwr_en(cwr_en),
    .cwr_word(cwr_word), .cwr_data(cwr_data), .line_commit(line_commit)
  );

  function automatic logic [DW-1:0] mk(input int line, input int w);
    return (DW'(line) * 32'h9E3779B9) ^ (DW'(w) * 32'h01000193) ^ 32'h5A5A0000;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  // monitor of write port, commit and memory model
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) chk(!fill_on, "R6 mem_req during refill", 1, 0);
      if (cwr_en) begin
        chk(32'(cwr_word) == seq, "R3 word order", cwr_word, seq);
        chk(cwr_data == mk(fl, seq), "R3 write data", cwr_data, mk(fl, seq));
        if (seq == NW - 1) chk(line_commit && act_line == fl, "R7 commit with last word", line_commit, 1);
        else               chk(!line_commit, "R7 early commit", line_commit, 0);
        seq++;
      end else if (line_commit) chk(0, "R7 commit without write", 1, 0);
      if (line_commit) begin
        committed[act_line] = 1;
        fill_on = 0;
      end
      mem_valid = 1'b0;
      if (mem_req) begin
        fill_on = 1; fill_start = cyc; fl = act_line; seq = 0;
        mcnt = FIRST - 2; memw = 0; mem_act = 1;
      end else if (mem_act) begin
        if (mcnt > 0) mcnt--;
        else begin
          mem_valid = 1'b1;
          mem_data  = mk(fl, memw);
          memw++;
          if (memw == NW) mem_act = 0;
        end
      end
    end
  end

  task automatic do_req(input int line, input int word);
    int e, exp, t;
    bit hit;
    string tag;
    @(negedge clk); #1;
    hit = committed[line];
    e = cyc + 1;
    if (!fill_on) begin
      exp = e + FIRST + word; tag = "R4 release cycle";
    end else if (fl == LW'(line)) begin
      exp = mx(e, fill_start + FIRST + word);
      tag = (exp == e) ? "R5 buffered release" : "R4 in-flight release";
    end else begin
      exp = mx(e, fill_start + FIRST + NW) + FIRST + word; tag = "R6 stalled release";
    end
    req_valid = 1'b1; req_line = LW'(line); req_word = WI'(word);
    if (hit) begin
      @(negedge clk); #1;
      chk(!cpu_done, "R8 hit gives no release", cpu_done, 0);
      chk(!mem_req, "R8 hit gives no fill", mem_req, 0);
      req_valid = 1'b0;
    end else begin
      t = 0;
      do begin @(negedge clk); #1; t++; end while (!cpu_done && t < 80);
      chk(cpu_done, "R4 request never released", 0, 1);
      chk(cyc == exp, tag, cyc, exp);
      chk(cpu_data == mk(line, word), "R4 release data", cpu_data, mk(line, word));
      req_valid = 1'b0;
      @(negedge clk); #1;
      chk(!cpu_done, "R9 single release pulse", cpu_done, 0);
    end
  endtask

  initial begin
    int s;
    s = int'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!cpu_done && !mem_req && !cwr_en && !line_commit, "R1 outputs in reset", 1, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!cpu_done && !mem_req && !cwr_en && !line_commit, "R1 after reset", 1, 0);
    // R4/R7: word 7 released in the commit cycle
    do_req(2, 7);
    // R8: committed line is left to the cache
    do_req(2, 3);
    // R2/R4: word 0 released early, then R5 buffered word, then in-flight word
    do_req(3, 0);
    do_req(3, 0);
    do_req(3, 6);
    // R6: other line while refilling
    do_req(4, 1);
    do_req(9, 4);
    repeat (30) @(negedge clk);
    for (int i = 0; i < 150; i++) begin
      int gap;
      gap = int'($urandom_range(0, 14));
      repeat (gap) @(negedge clk);
      do_req(int'($urandom_range(0, (1 << LW) - 1)), int'($urandom_range(0, NW - 1)));
    end
    repeat (30) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule